// File: doc/BRIEF.md
# Group-Deferred Register Commit Unit

This block models architectural state for an instruction stream split into groups. One operation arrives per clock: a register read, a register write, a memory read or a memory write, with an address and write data. Register writes made inside a group are parked in a small pending buffer. The register file only changes on the clock edge that closes the group, so every register read inside a group returns the value from before the group started. This holds whether the writer comes earlier or later in the group.

Memory works differently. A memory write lands in the array on its own clock edge, so any later operation in the same group reads the new data. The end-of-group strobe commits every pending register write, including one presented in the closing cycle. Every read of the next group therefore sees the complete result of the previous group.

A conflict flag reports two cases: a register written twice in one group, and a write to a new register when the buffer has no free slot. In the first case the later value wins. In the second case the write is discarded. The flag stays up until the group closes.

Top module: `grp_commit_unit`

## Requirements
- R1: After reset, every register and every memory word reads 0, and `conflict` is 0.
- R2: A register read (`op_kind` = 0) returns the value committed before the current group began, even when the same register was written earlier in this group or is written in the closing cycle. The register index is the low `REG_IDX_W` bits of `op_addr`.
- R3: On the clock edge where `group_end` is 1, all pending register writes are committed to the register file. This includes a register write (`op_kind` = 1) presented in that same cycle. A register read in the next cycle returns the committed values.
- R4: A memory write (`op_kind` = 3) updates the word at `op_addr` on its clock edge. A memory read (`op_kind` = 2) in a later cycle of the same group returns the new data, and memory reads are combinational.
- R5: A second write to a register that already has a pending write in the group raises `conflict` in that cycle. It replaces the pending value, so the later value is the one committed, and it takes no additional buffer slot.
- R6: A register write to a register without a pending entry, made when `PEND_DEPTH` distinct registers are already pending, raises `conflict` and is dropped. After the group closes, that register keeps its old value.
- R7: Once raised, `conflict` stays 1 for the rest of the group, including the closing cycle. It is 0 in the cycle after the closing edge unless a new conflict occurs in that cycle.
- R8: `rd_data` is 0 when `op_valid` is 0 or when the operation is a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to `clk` |
| op_valid | input | 1 | An operation is presented this cycle |
| op_kind | input | 2 | 0 register read, 1 register write, 2 memory read, 3 memory write |
| op_addr | input | ADDR_W | Memory word address; the low REG_IDX_W bits select the register |
| op_wdata | input | DATA_W | Write data for register or memory writes |
| group_end | input | 1 | The current group closes on this clock edge |
| rd_data | output | DATA_W | Combinational read result |
| conflict | output | 1 | Duplicate or dropped register write in the current group |

## Verification
The bench builds the unit with `PEND_DEPTH` = 4 and keeps 16 registers of 32 bits and 64 memory words. With the shallow buffer, an overflow is reached after four distinct writes. This lets one short group test the drop path, a duplicate write issued while the buffer is full, and the rule that repeated writes to one register take no extra slot. The 6-bit address is wider than the 4-bit register index, so register reads and memory accesses share address bits while acting on separate state.

// File: rtl/grp_commit_pkg.sv
package grp_commit_pkg;

  typedef enum logic [1:0] {
    OP_RREG = 2'd0,
    OP_WREG = 2'd1,
    OP_RMEM = 2'd2,
    OP_WMEM = 2'd3
  } op_kind_e;

endpackage

// File: rtl/gcu_pend_buf.sv
module gcu_pend_buf #(
  parameter int DEPTH  = 8,
  parameter int IDX_W  = 4,
  parameter int DATA_W = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [IDX_W-1:0]              wr_idx,
  input  logic [DATA_W-1:0]             wr_data,
  input  logic                          close,
  output logic [DEPTH-1:0]              mrg_vld,
  output logic [DEPTH-1:0][IDX_W-1:0]   mrg_idx,
  output logic [DEPTH-1:0][DATA_W-1:0]  mrg_dat,
  output logic [CNT_W-1:0]              occ,
  output logic                          dup_evt,
  output logic                          drop_evt
);

  logic [DEPTH-1:0]             vld_q, vld_d;
  logic [DEPTH-1:0][IDX_W-1:0]  idx_q, idx_d;
  logic [DEPTH-1:0][DATA_W-1:0] dat_q, dat_d;
  logic [CNT_W-1:0]             cnt_q, cnt_d;
  logic [DEPTH-1:0]             hit;
  logic                         buf_en;

  // Next state: merge the incoming write into the buffer image
  always_comb begin
    vld_d    = vld_q;
    idx_d    = idx_q;
    dat_d    = dat_q;
    cnt_d    = cnt_q;
    dup_evt  = 1'b0;
    drop_evt = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      hit[i] = vld_q[i] && (idx_q[i] == wr_idx);
    end
    if (wr_en) begin
      if (|hit) begin
        dup_evt = 1'b1;
        for (int i = 0; i < DEPTH; i++) begin
          if (hit[i]) dat_d[i] = wr_data;
        end
      end else if (cnt_q == CNT_W'(DEPTH)) begin
        drop_evt = 1'b1;
      end else begin
        for (int i = 0; i < DEPTH; i++) begin
          if (CNT_W'(i) == cnt_q) begin
            vld_d[i] = 1'b1;
            idx_d[i] = wr_idx;
            dat_d[i] = wr_data;
          end
        end
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  assign buf_en = wr_en | close;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      idx_q <= '0;
      dat_q <= '0;
      cnt_q <= '0;
    end else if (buf_en) begin
      if (close) begin
        vld_q <= '0;
        cnt_q <= '0;
      end else begin
        vld_q <= vld_d;
        idx_q <= idx_d;
        dat_q <= dat_d;
        cnt_q <= cnt_d;
      end
    end
  end

  assign mrg_vld = vld_d;
  assign mrg_idx = idx_d;
  assign mrg_dat = dat_d;
  assign occ     = cnt_q;

endmodule

// File: rtl/gcu_reg_file.sv
module gcu_reg_file #(
  parameter int REG_COUNT = 16,
  parameter int DEPTH     = 8,
  parameter int DATA_W    = 32,
  localparam int IDX_W    = $clog2(REG_COUNT)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          commit,
  input  logic [DEPTH-1:0]              mrg_vld,
  input  logic [DEPTH-1:0][IDX_W-1:0]   mrg_idx,
  input  logic [DEPTH-1:0][DATA_W-1:0]  mrg_dat,
  input  logic [IDX_W-1:0]              rd_idx,
  output logic [DATA_W-1:0]             rd_val
);

  logic [REG_COUNT-1:0][DATA_W-1:0] words;

  for (genvar r = 0; r < REG_COUNT; r++) begin : g_reg
    logic              sel;
    logic [DATA_W-1:0] sel_dat;
    logic [DATA_W-1:0] word_q;
    logic              word_en;

    always_comb begin
      sel     = 1'b0;
      sel_dat = '0;
      for (int e = 0; e < DEPTH; e++) begin
        if (mrg_vld[e] && (mrg_idx[e] == IDX_W'(r))) begin
          sel     = 1'b1;
          sel_dat = mrg_dat[e];
        end
      end
    end

    assign word_en = commit & sel;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
      end else if (word_en) begin
        word_q <= sel_dat;
      end
    end

    assign words[r] = word_q;
  end

  assign rd_val = words[rd_idx];

endmodule

// File: rtl/gcu_mem_array.sv
module gcu_mem_array #(
  parameter int MEM_DEPTH = 64,
  parameter int DATA_W    = 32,
  localparam int AW       = $clog2(MEM_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [MEM_DEPTH-1:0][DATA_W-1:0] words;

  for (genvar w = 0; w < MEM_DEPTH; w++) begin : g_word
    logic [DATA_W-1:0] word_q;
    logic              word_en;

    assign word_en = we && (addr == AW'(w));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
      end else if (word_en) begin
        word_q <= wdata;
      end
    end

    assign words[w] = word_q;
  end

  assign rdata = words[addr];

endmodule

// File: rtl/grp_commit_unit.sv
module grp_commit_unit
  import grp_commit_pkg::*;
#(
  parameter int REG_COUNT  = 16,
  parameter int DATA_W     = 32,
  parameter int PEND_DEPTH = 8,
  parameter int MEM_DEPTH  = 64,
  localparam int REG_IDX_W  = $clog2(REG_COUNT),
  localparam int MEM_ADDR_W = $clog2(MEM_DEPTH),
  localparam int ADDR_W     = (MEM_ADDR_W > REG_IDX_W) ? MEM_ADDR_W : REG_IDX_W,
  localparam int CNT_W      = $clog2(PEND_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [1:0]        op_kind,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [DATA_W-1:0] op_wdata,
  input  logic              group_end,
  output logic [DATA_W-1:0] rd_data,
  output logic              conflict
);

  op_kind_e                            kind;
  logic                                reg_wr, mem_wr;
  logic [REG_IDX_W-1:0]                reg_idx;
  logic [PEND_DEPTH-1:0]               mrg_vld;
  logic [PEND_DEPTH-1:0][REG_IDX_W-1:0] mrg_idx;
  logic [PEND_DEPTH-1:0][DATA_W-1:0]   mrg_dat;
  logic [CNT_W-1:0]                    pend_cnt;
  logic                                dup_evt, drop_evt, cfl_evt;
  logic                                conflict_q, conflict_d, conflict_en;
  logic [DATA_W-1:0]                   reg_rd, mem_rd;

  assign kind    = op_kind_e'(op_kind);
  assign reg_wr  = op_valid && (kind == OP_WREG);
  assign mem_wr  = op_valid && (kind == OP_WMEM);
  assign reg_idx = op_addr[REG_IDX_W-1:0];

  gcu_pend_buf #(
    .DEPTH (PEND_DEPTH),
    .IDX_W (REG_IDX_W),
    .DATA_W(DATA_W)
  ) u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr),
    .wr_idx  (reg_idx),
    .wr_data (op_wdata),
    .close   (group_end),
    .mrg_vld (mrg_vld),
    .mrg_idx (mrg_idx),
    .mrg_dat (mrg_dat),
    .occ     (pend_cnt),
    .dup_evt (dup_evt),
    .drop_evt(drop_evt)
  );

  gcu_reg_file #(
    .REG_COUNT(REG_COUNT),
    .DEPTH    (PEND_DEPTH),
    .DATA_W   (DATA_W)
  ) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .commit (group_end),
    .mrg_vld(mrg_vld),
    .mrg_idx(mrg_idx),
    .mrg_dat(mrg_dat),
    .rd_idx (reg_idx),
    .rd_val (reg_rd)
  );

  gcu_mem_array #(
    .MEM_DEPTH(MEM_DEPTH),
    .DATA_W   (DATA_W)
  ) u_mem (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (mem_wr),
    .addr (op_addr[MEM_ADDR_W-1:0]),
    .wdata(op_wdata),
    .rdata(mem_rd)
  );

  // Read result selection
  always_comb begin
    rd_data = '0;
    if (op_valid) begin
      case (kind)
        OP_RREG: rd_data = reg_rd;
        OP_RMEM: rd_data = mem_rd;
        default: rd_data = '0;
      endcase
    end
  end

  // Group-scoped conflict flag
  assign cfl_evt     = dup_evt | drop_evt;
  assign conflict_en = group_end | cfl_evt;
  assign conflict_d  = group_end ? 1'b0 : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conflict_q <= 1'b0;
    end else if (conflict_en) begin
      conflict_q <= conflict_d;
    end
  end

  assign conflict = conflict_q | cfl_evt;

endmodule

// File: rtl/gcu_checker.sv
module gcu_checker #(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 32,
  parameter int PEND_DEPTH = 8,
  parameter int CNT_W      = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic [1:0]        op_kind,
  input logic [ADDR_W-1:0] op_addr,
  input logic [DATA_W-1:0] op_wdata,
  input logic              group_end,
  input logic [DATA_W-1:0] rd_data,
  input logic              conflict,
  input logic [CNT_W-1:0]  pend_cnt
);

  logic seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  // R2: back-to-back reads of one register inside a group agree
  a_r2_reg_read_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && op_valid && op_kind == 2'd0 && $past(op_valid) &&
     $past(op_kind) == 2'd0 && !$past(group_end) && op_addr == $past(op_addr))
    |-> rd_data == $past(rd_data));

  // R3: the buffer is empty after a closing edge
  a_r3_buf_empty: assert property (@(posedge clk) disable iff (!rst_n)
    group_end |=> pend_cnt == '0);

  // R4: a memory write is visible to a memory read in the next cycle
  a_r4_mem_forward: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && op_valid && op_kind == 2'd2 && $past(op_valid) &&
     $past(op_kind) == 2'd3 && op_addr == $past(op_addr))
    |-> rd_data == $past(op_wdata));

  // R6: occupancy never exceeds the buffer depth
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    pend_cnt <= CNT_W'(PEND_DEPTH));

  // R7: conflict holds within a group
  a_r7_conflict_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (conflict && !group_end) |=> conflict);

  // R7: conflict drops after the group closes, absent a write
  a_r7_conflict_clears: assert property (@(posedge clk) disable iff (!rst_n)
    group_end |=> (op_valid || !conflict));

  // R8: idle cycles return zero
  a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |-> rd_data == '0);

endmodule

bind grp_commit_unit gcu_checker #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .PEND_DEPTH(PEND_DEPTH),
  .CNT_W     (CNT_W)
) u_gcu_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .op_valid (op_valid),
  .op_kind  (op_kind),
  .op_addr  (op_addr),
  .op_wdata (op_wdata),
  .group_end(group_end),
  .rd_data  (rd_data),
  .conflict (conflict),
  .pend_cnt (pend_cnt)
);

// File: tb/test_grp_commit_unit.sv
module test_grp_commit_unit;

  localparam int DW = 32;
  localparam int AW = 6;

  logic          clk;
  logic          rst_n;
  logic          op_valid;
  logic [1:0]    op_kind;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] op_wdata;
  logic          group_end;
  logic [DW-1:0] rd_data;
  logic          conflict;

  int n_chk  = 0;
  int n_fail = 0;

  localparam logic [1:0] K_RR = 2'd0, K_WR = 2'd1, K_RM = 2'd2, K_WM = 2'd3;

  grp_commit_unit #(
    .REG_COUNT (16),
    .DATA_W    (DW),
    .PEND_DEPTH(4),
    .MEM_DEPTH (64)
  ) i_grp_commit_unit (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_kind  (op_kind),
    .op_addr  (op_addr),
    .op_wdata (op_wdata),
    .group_end(group_end),
    .rd_data  (rd_data),
    .conflict (conflict)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One cycle: drive at the falling edge, settle, leave outputs for sampling
  task automatic put(input logic v, input logic [1:0] k, input logic [AW-1:0] a,
                     input logic [DW-1:0] d, input logic ge);
    @(negedge clk);
    op_valid  = v;
    op_kind   = k;
    op_addr   = a;
    op_wdata  = d;
    group_end = ge;
    #2;
  endtask

  task automatic idle(input logic ge);
    put(1'b0, K_RR, '0, '0, ge);
  endtask

  task automatic t_reset;
    idle(1'b0);
    chk("R1 conflict after reset", {31'd0, conflict}, 32'd0);
    chk("R8 idle rd_data", rd_data, 32'd0);
    put(1'b1, K_RR, 6'd5, '0, 1'b0);
    chk("R1 register 5 after reset", rd_data, 32'd0);
    put(1'b1, K_RM, 6'd42, '0, 1'b0);
    chk("R1 memory 42 after reset", rd_data, 32'd0);
  endtask

  task automatic t_reg_defer;
    put(1'b1, K_WR, 6'd3, 32'hA000_0003, 1'b0);
    chk("R8 write returns zero", rd_data, 32'd0);
    put(1'b1, K_RR, 6'd3, '0, 1'b0);
    chk("R2 read after in-group write", rd_data, 32'd0);
    put(1'b1, K_RR, 6'd4, '0, 1'b0);
    chk("R2 read before later write", rd_data, 32'd0);
    put(1'b1, K_WR, 6'd4, 32'hB000_0004, 1'b0);
    put(1'b1, K_RR, 6'd3, '0, 1'b1);
    chk("R2 read in closing cycle", rd_data, 32'd0);
    put(1'b1, K_RR, 6'd3, '0, 1'b0);
    chk("R3 register 3 committed", rd_data, 32'hA000_0003);
    put(1'b1, K_RR, 6'd4, '0, 1'b0);
    chk("R3 register 4 committed", rd_data, 32'hB000_0004);
    put(1'b1, K_WR, 6'd7, 32'hC000_0007, 1'b1);
    put(1'b1, K_RR, 6'd7, '0, 1'b0);
    chk("R3 write in closing cycle committed", rd_data, 32'hC000_0007);
    put(1'b1, K_WR, 6'd3, 32'hD000_0003, 1'b0);
    put(1'b1, K_RR, 6'd3, '0, 1'b0);
    chk("R2 old committed value kept", rd_data, 32'hA000_0003);
    idle(1'b1);
    put(1'b1, K_RR, 6'd3, '0, 1'b0);
    chk("R3 overwrite committed", rd_data, 32'hD000_0003);
  endtask

  task automatic t_mem;
    put(1'b1, K_WM, 6'd20, 32'h1111_2020, 1'b0);
    chk("R8 memory write returns zero", rd_data, 32'd0);
    put(1'b1, K_RM, 6'd20, '0, 1'b0);
    chk("R4 in-group memory read", rd_data, 32'h1111_2020);
    put(1'b1, K_WM, 6'd20, 32'h2222_2020, 1'b0);
    put(1'b1, K_RM, 6'd20, '0, 1'b0);
    chk("R4 second store visible", rd_data, 32'h2222_2020);
    put(1'b1, K_RR, 6'd20, '0, 1'b0);
    chk("R4 register 4 untouched by memory", rd_data, 32'hB000_0004);
    idle(1'b1);
  endtask

  task automatic t_dup;
    put(1'b1, K_WR, 6'd9, 32'h0000_0099, 1'b0);
    chk("R5 first write no conflict", {31'd0, conflict}, 32'd0);
    put(1'b1, K_WR, 6'd9, 32'h0000_9999, 1'b0);
    chk("R5 duplicate raises conflict", {31'd0, conflict}, 32'd1);
    put(1'b1, K_WR, 6'd1, 32'h0000_0001, 1'b0);
    put(1'b1, K_WR, 6'd2, 32'h0000_0002, 1'b0);
    put(1'b1, K_WR, 6'd5, 32'h0000_0005, 1'b0);
    chk("R7 conflict held", {31'd0, conflict}, 32'd1);
    idle(1'b1);
    chk("R7 conflict in closing cycle", {31'd0, conflict}, 32'd1);
    idle(1'b0);
    chk("R7 conflict cleared", {31'd0, conflict}, 32'd0);
    put(1'b1, K_RR, 6'd9, '0, 1'b0);
    chk("R5 later value committed", rd_data, 32'h0000_9999);
    put(1'b1, K_RR, 6'd5, '0, 1'b0);
    chk("R5 duplicate took no slot", rd_data, 32'h0000_0005);
  endtask

  task automatic t_full;
    for (int i = 10; i < 14; i++) begin
      put(1'b1, K_WR, AW'(i), 32'hF000_0000 | i, 1'b0);
    end
    chk("R6 four distinct writes no conflict", {31'd0, conflict}, 32'd0);
    put(1'b1, K_WR, 6'd14, 32'hEEEE_0014, 1'b0);
    chk("R6 write when full raises conflict", {31'd0, conflict}, 32'd1);
    put(1'b1, K_WR, 6'd10, 32'h0000_1010, 1'b1);
    put(1'b1, K_RR, 6'd14, '0, 1'b0);
    chk("R6 dropped write not committed", rd_data, 32'd0);
    put(1'b1, K_RR, 6'd13, '0, 1'b0);
    chk("R6 last fitting write committed", rd_data, 32'hF000_000D);
    put(1'b1, K_RR, 6'd10, '0, 1'b0);
    chk("R5 duplicate while full replaces", rd_data, 32'h0000_1010);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R1..R8 run actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    op_valid  = 1'b0;
    op_kind   = K_RR;
    op_addr   = '0;
    op_wdata  = '0;
    group_end = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_reg_defer();
    t_mem();
    t_dup();
    t_full();
    idle(1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule